// File: doc/BRIEF.md
# Burst-Mode Converter Power Sequencer

This block keeps an external 8-bit multichannel analog-to-digital converter in its low-current state between measurement bursts. Each periodic tick starts a burst. The block releases the converter's active-low shutdown control and waits a fixed wake time. That time covers the power-up delay and the input acquisition. The block then issues a bounded series of conversion requests to a separate bus interface block, which owns the pin-level timing.

Each returned sample goes downstream with the channel it was taken from. After the last sample of the burst is accepted, the block shuts the converter down again. The first conversion after reset only initializes the converter, so its data is dropped. A tick that arrives while a burst is running does not start anything. It only increments an overrun count.

Top module: `burst_pwr_ctrl`

## Requirements
- R1: In the cycle after a reset clock edge, `conv_awake`, `conv_req` and `res_valid` are low and `overrun_cnt` is zero.
- R2: A `tick` sampled while idle with a nonzero `cfg_len` drives `conv_awake` high at that clock edge. A `tick` while idle with `cfg_len` equal to zero has no effect.
- R3: `conv_req` first rises exactly WAKE_CYC clock edges after `conv_awake` rises. WAKE_CYC = ceil(WAKE_NS / CLK_PERIOD_NS), which is 36 with the defaults.
- R4: The first conversion after reset uses the channel in slot 0, and its data is not forwarded. Later bursts perform no discarded conversion.
- R5: Conversion k of a burst (k counted from 0) uses the channel in slot k. Slot k is bits [3k+2:3k] of `cfg_list`, captured at the starting tick. `conv_ch` stays stable while a request is waiting for `conv_ack`.
- R6: The burst length is `cfg_len`, captured at the starting tick. Values above 8 are treated as 8.
- R7: When `conv_req` and `conv_ack` are both high at an edge, `conv_data` is captured. From the next cycle `res_valid` is high, with that data on `res_data` and the request's channel on `res_chan`. These values hold until `res_ready` is sampled high.
- R8: `conv_awake` falls at the edge that follows acceptance of the burst's last result, and never earlier.
- R9: A `tick` sampled while a burst is in progress increments `overrun_cnt`, which saturates at its maximum value. It has no other effect.
- R10: `conv_req` is high only while `conv_awake` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Periodic burst start strobe |
| cfg_len | input | LEN_W | Conversions per burst (0 = skip, above SLOTS = SLOTS) |
| cfg_list | input | SLOTS*CH_W | Channel address for each conversion slot |
| conv_awake | output | 1 | Converter shutdown control, low = powered down |
| conv_req | output | 1 | Conversion request to the bus interface block |
| conv_ch | output | CH_W | Channel address for the pending request |
| conv_ack | input | 1 | Conversion finished, data valid this cycle |
| conv_data | input | DATA_W | Conversion result |
| res_valid | output | 1 | Result available downstream |
| res_ready | input | 1 | Downstream accepts result |
| res_data | output | DATA_W | Result sample |
| res_chan | output | CH_W | Channel tag of the result |
| overrun_cnt | output | OVR_W | Saturating count of ticks lost during bursts |

## Verification
Every output of the block is registered. `conv_awake` therefore changes at the edge where the tick is sampled. `conv_req` follows WAKE_CYC edges later. A result appears at the edge after its acknowledge, and `conv_awake` drops at the edge that takes the last result. A behavioural model in the bench advances on the same edges from the same sampled inputs. It predicts every output for every cycle, and the outputs are compared at the falling edge, half a period after the edge that updates them. The converter side and the downstream side are driven with pseudo-random acknowledge and ready patterns. This moves each event to a different cycle in every burst.

// File: rtl/burst_pkg.sv
// Shared types for the burst power sequencer.
package burst_pkg;
    // Sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // converter shut down
        PH_WAKE = 2'd1,  // waiting for power-up plus acquisition
        PH_CONV = 2'd2,  // conversion request outstanding
        PH_OUT  = 2'd3   // result offered downstream
    } burst_ph_t;
endpackage

// File: rtl/wake_timer.sv
// Wake timer: after a start strobe, raises done once CYC edges have passed.
// Assumes CYC >= 1 and that start is not pulsed while the timer runs.
module wake_timer #(
    parameter int CYC = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;
    logic          run;

    // Load on start, count down to zero, stop after done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= CW'(CYC - 1);
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    // Done is high in the last cycle of the wait.
    always_comb done = run && (cnt == '0);
endmodule

// File: rtl/slot_mux.sv
// Slot selector: picks one channel address out of a packed slot list.
// Assumes idx < SLOTS. Out-of-range indices return slot 0.
module slot_mux #(
    parameter int SLOTS = 8,
    parameter int CH_W  = 3
) (
    input  logic [SLOTS*CH_W-1:0]       list,
    input  logic [$clog2(SLOTS+1)-1:0]  idx,
    output logic [CH_W-1:0]             ch
);
    logic [CH_W-1:0] slot [SLOTS];

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_unpack
            assign slot[g] = list[g*CH_W +: CH_W];
        end
    endgenerate

    // Select the indexed slot.
    always_comb begin
        ch = slot[0];
        for (int i = 0; i < SLOTS; i++)
            if (idx == ($clog2(SLOTS+1))'(i)) ch = slot[i];
    end
endmodule

// File: rtl/sat_counter.sv
// Saturating event counter: adds one per inc strobe, holds at all-ones.
module sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Increment unless already at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (inc && (cnt != '1)) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/burst_pwr_ctrl.sv
// Burst-mode power sequencer for an external multichannel converter.
// On tick it wakes the converter, waits WAKE_CYC cycles, discards the first
// conversion after reset, runs cfg_len conversions over the slot list and
// powers down once the last result is taken. Assumes the bus interface block
// holds conv_ack for a single cycle per request and observes the
// converter's minimum acquisition time between requests.
module burst_pwr_ctrl
    import burst_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CH_W          = 3,
    parameter int SLOTS         = 8,
    parameter int LEN_W         = 4,
    parameter int OVR_W         = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int WAKE_NS       = 360
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [LEN_W-1:0]      cfg_len,
    input  logic [SLOTS*CH_W-1:0] cfg_list,
    output logic                  conv_awake,
    output logic                  conv_req,
    output logic [CH_W-1:0]       conv_ch,
    input  logic                  conv_ack,
    input  logic [DATA_W-1:0]     conv_data,
    output logic                  res_valid,
    input  logic                  res_ready,
    output logic [DATA_W-1:0]     res_data,
    output logic [CH_W-1:0]       res_chan,
    output logic [OVR_W-1:0]      overrun_cnt
);
    localparam int WAKE_RAW = (WAKE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int WAKE_CYC = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
    localparam int IDX_W    = $clog2(SLOTS + 1);

    burst_ph_t             ph;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W-1:0]      len_q;
    logic [IDX_W-1:0]      sel_idx;
    logic [SLOTS*CH_W-1:0] list_q;
    logic                  primed;
    logic                  discard;
    logic                  start;
    logic                  wake_done;
    logic [IDX_W-1:0]      len_eff;
    logic                  take;
    logic                  last;

    // Clamp requested length to the slot count.
    always_comb begin
        if (cfg_len > LEN_W'(SLOTS)) len_eff = IDX_W'(SLOTS);
        else                         len_eff = IDX_W'(cfg_len);
    end

    // Burst start and handshake qualifiers.
    always_comb begin
        start = (ph == PH_IDLE) && tick && (cfg_len != '0);
        take  = (ph == PH_CONV) && conv_ack;
        last  = (idx + 1'b1) == len_q;
    end

    // Main phase sequencing and burst bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph         <= PH_IDLE;
            idx        <= '0;
            len_q      <= '0;
            list_q     <= '0;
            primed     <= 1'b0;
            discard    <= 1'b0;
            conv_awake <= 1'b0;
        end else begin
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph         <= PH_WAKE;
                    idx        <= '0;
                    len_q      <= len_eff;
                    list_q     <= cfg_list;
                    discard    <= !primed;
                    conv_awake <= 1'b1;
                end
                PH_WAKE: if (wake_done) ph <= PH_CONV;
                PH_CONV: if (conv_ack) begin
                    if (discard) begin
                        discard <= 1'b0;
                        primed  <= 1'b1;
                    end else begin
                        ph <= PH_OUT;
                    end
                end
                PH_OUT: if (res_ready) begin
                    if (last) begin
                        ph         <= PH_IDLE;
                        conv_awake <= 1'b0;
                    end else begin
                        idx <= idx + 1'b1;
                        ph  <= PH_CONV;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Request and result-valid flags follow the phase.
    always_comb begin
        conv_req  = (ph == PH_CONV);
        res_valid = (ph == PH_OUT);
        sel_idx   = discard ? '0 : idx;
    end

    // Capture a kept sample and its channel tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
            res_chan <= '0;
        end else if (take && !discard) begin
            res_data <= conv_data;
            res_chan <= conv_ch;
        end
    end

    wake_timer #(.CYC(WAKE_CYC)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .done  (wake_done)
    );

    slot_mux #(.SLOTS(SLOTS), .CH_W(CH_W)) u_slot (
        .list (list_q),
        .idx  (sel_idx),
        .ch   (conv_ch)
    );

    sat_counter #(.W(OVR_W)) u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick && (ph != PH_IDLE)),
        .cnt   (overrun_cnt)
    );
endmodule

// File: rtl/burst_pwr_chk.sv
// Property checker for burst_pwr_ctrl, bound to every instance.
module burst_pwr_chk #(
    parameter int DATA_W = 8,
    parameter int CH_W   = 3,
    parameter int OVR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_awake,
    input logic              conv_req,
    input logic [CH_W-1:0]   conv_ch,
    input logic              conv_ack,
    input logic              res_valid,
    input logic              res_ready,
    input logic [DATA_W-1:0] res_data,
    input logic [CH_W-1:0]   res_chan,
    input logic [OVR_W-1:0]  overrun_cnt
);
    // R10
    req_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> conv_awake);

    // R5
    chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && $past(conv_req && !conv_ack)) |-> $stable(conv_ch));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)));

    // R8
    sleep_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_awake) |-> $past(res_valid && res_ready));

    // R9
    overrun_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (overrun_cnt >= $past(overrun_cnt)));

    // R7
    no_req_while_offering_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_req && res_valid));
endmodule

bind burst_pwr_ctrl burst_pwr_chk #(
    .DATA_W (DATA_W),
    .CH_W   (CH_W),
    .OVR_W  (OVR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_awake  (conv_awake),
    .conv_req    (conv_req),
    .conv_ch     (conv_ch),
    .conv_ack    (conv_ack),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_data    (res_data),
    .res_chan    (res_chan),
    .overrun_cnt (overrun_cnt)
);

// File: tb/sim_burst_pwr_ctrl.sv
// Bench: behavioural model of the sequencer compared on every clock.
module sim_burst_pwr_ctrl;
    localparam int CLK_NS  = 10;
    localparam int WAKE    = 36;
    localparam int OVR_MAX = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  cfg_len = '0;
    logic [23:0] cfg_list = '0;
    logic        conv_awake, conv_req, res_valid;
    logic [2:0]  conv_ch, res_chan;
    logic        conv_ack = 1'b0;
    logic [7:0]  conv_data = '0;
    logic        res_ready = 1'b0;
    logic [7:0]  res_data;
    logic [2:0]  overrun_cnt;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit cmp_on = 0;
    bit ready_always = 1;
    logic [15:0] lfsr = 16'hACE1;

    burst_pwr_ctrl #(.OVR_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len),
        .cfg_list(cfg_list), .conv_awake(conv_awake), .conv_req(conv_req),
        .conv_ch(conv_ch), .conv_ack(conv_ack), .conv_data(conv_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_chan(res_chan), .overrun_cnt(overrun_cnt)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Reference model state
    int         m_ph = 0;      // 0 asleep, 1 waking, 2 requesting, 3 offering
    int         m_wait = 0;
    bit         m_first = 1;
    bit         m_drop = 0;
    bit         m_awake = 0;
    int         m_ovr = 0;
    logic [7:0] m_data = '0;
    logic [2:0] m_chan = '0;
    logic [2:0] chq[$];

    always @(posedge clk) begin
        int prev;
        prev = m_ph;
        if (!rst_n) begin
            m_ph = 0; m_first = 1; m_drop = 0; m_awake = 0; m_ovr = 0;
            chq.delete();
            cmp_on = 1;
        end else begin
            if (prev != 0 && tick && m_ovr < OVR_MAX) m_ovr++;
            case (prev)
                0: if (tick && cfg_len != 0) begin
                    int n;
                    n = (cfg_len > 8) ? 8 : int'(cfg_len);
                    chq.delete();
                    if (m_first) chq.push_back(cfg_list[2:0]);
                    for (int k = 0; k < n; k++) chq.push_back(cfg_list[k*3 +: 3]);
                    m_drop = m_first;
                    m_first = 0;
                    m_awake = 1;
                    m_wait = WAKE;
                    m_ph = 1;
                end
                1: begin
                    m_wait--;
                    if (m_wait == 0) m_ph = 2;
                end
                2: if (conv_ack) begin
                    if (m_drop) begin
                        m_drop = 0;
                        void'(chq.pop_front());
                    end else begin
                        m_data = conv_data;
                        m_chan = chq.pop_front();
                        m_ph = 3;
                    end
                end
                default: if (res_ready) begin
                    if (chq.size() == 0) begin m_ph = 0; m_awake = 0; end
                    else m_ph = 2;
                end
            endcase
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cycles, act, exp);
        end
    endtask

    // Compare outputs half a period after the updating edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R1/R2/R8", "conv_awake", int'(conv_awake), int'(m_awake));
            check("R3/R10", "conv_req", int'(conv_req), (m_ph == 2) ? 1 : 0);
            check("R7", "res_valid", int'(res_valid), (m_ph == 3) ? 1 : 0);
            check("R9", "overrun_cnt", int'(overrun_cnt), m_ovr);
            if (m_ph == 2 && chq.size() > 0)
                check("R4/R5/R6", "conv_ch", int'(conv_ch), int'(chq[0]));
            if (m_ph == 3) begin
                check("R7", "res_data", int'(res_data), int'(m_data));
                check("R4/R5", "res_chan", int'(res_chan), int'(m_chan));
            end
        end
    end

    // Converter-side and downstream stimulus with pseudo-random timing.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        conv_ack  = conv_req && lfsr[0];
        conv_data = lfsr[15:8];
        res_ready = ready_always ? 1'b1 : lfsr[3];
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic start_burst(input logic [3:0] len, input logic [23:0] list);
        @(negedge clk);
        tick = 1'b1; cfg_len = len; cfg_list = list;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wait_asleep();
        int n = 0;
        do begin @(negedge clk); n++; end while ((m_ph != 0) && n < 5000);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);       // R1 reset state compared here
        start_burst(4'd0, 24'hFFFFFF);   // R2 zero length ignored
        repeat (10) @(negedge clk);
        // R4 first burst carries the discarded conversion; R3 wake timing
        start_burst(4'd4, {12'h000, 3'd1, 3'd5, 3'd3, 3'd7});
        wait_asleep();
        // R6 clamp to 8, R9 overrun saturation, R7 stalls downstream
        ready_always = 0;
        start_burst(4'd12, {3'd7, 3'd3, 3'd5, 3'd1, 3'd4, 3'd0, 3'd6, 3'd2});
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); tick = 1'b1; cfg_len = 4'd2;
            @(negedge clk); tick = 1'b0;
        end
        wait_asleep();
        // R5 single conversion, no discard any more
        start_burst(4'd1, {21'h0, 3'd6});
        wait_asleep();
        start_burst(4'd8, 24'h2C6A5F);
        wait_asleep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule